// File: doc/BRIEF.md
# Caption Clock Run-In Window Detector

This block watches the sliced data bit of a video line for the short burst of clock run-in pulses that comes before closed-caption data. Each falling edge of horizontal sync opens a new line. A position counter then runs in reference-clock cycles. Rising transitions of the synchronized sliced data are counted only while that position lies inside a programmable window, given by a start and a length. When the window closes, the block judges the burst valid if the count is 4, 5 or 6.

A line-select input, sampled at the sync falling edge, marks the line as either the main slice line or the sub slice line. Each kind of line keeps its own pulse count. A small write port loads the window start, the window length and a control byte. Window values are staged and only become active at the next sync falling edge. The control byte picks which line kind may raise the interrupt request. It also picks the trigger: either the close of the window, which ends the line's decision, or a caption-latch completion pulse from the downstream data shift register. A read-only flag reports that caption data on a sub line has been latched.

Top module: `caption_runin_det`

## Requirements
- R1: Let k be the number of clock edges since the edge that sampled the sync falling edge (hsync high on the previous edge, low on this one). A 0-to-1 change of slice_in applied during cycle k is counted when start <= k+2 < start+length, using the active window values.
- R2: line_sel sampled at the sync falling edge chooses the line kind (0 main, 1 sub). That edge clears only that kind's count, and only that count increments during the line. The other count keeps its value.
- R3: A pulse count saturates at 7 and never wraps to 0.
- R4: runin_ok is cleared at the sync falling edge. It is loaded one edge after the window closes (position equals start+length) with 1 exactly when the line's count is 4 to 6.
- R5: Writes to wr_addr 0 (window start) and wr_addr 1 (window length) are staged and take effect only at the next sync falling edge. A write that lands on the same edge as the sync fall is used for the line that begins at that edge.
- R6: sub_latched goes to 1 one edge after latch_done is high during a sub line. It stays 0 on main lines and is cleared at the sync falling edge.
- R7: A write to wr_addr 2 sets the control byte immediately. Bit 0 selects the interrupting line kind (0 main, 1 sub). Bit 1 selects the trigger (0 window close, 1 latch completion).
- R8: In window-close mode, irq is a one-cycle pulse one edge after the window closes, and only when the current line kind matches control bit 0.
- R9: In latch mode, irq is a one-cycle pulse one edge after latch_done, and only when the current line kind matches control bit 0.
- R10: After reset both counts, runin_ok, sub_latched and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_in | input | 1 | Sliced video data bit |
| hsync | input | 1 | Horizontal sync, falling edge starts a line |
| line_sel | input | 1 | Line kind for the next line: 0 main, 1 sub |
| latch_done | input | 1 | One-cycle caption-latch completion pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 window start, 1 window length, 2 control |
| wr_data | input | DW | Register write data |
| main_count | output | CNT_W | Pulse count of the last main line |
| sub_count | output | CNT_W | Pulse count of the last sub line |
| runin_ok | output | 1 | Run-in judged valid for the current line |
| sub_latched | output | 1 | Caption data latched on the current sub line |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Two things can fall on the same clock edge: the sync falling edge that loads the active window, and a CPU write to the staged window start. The bench provokes this on about half of the swept lines. It first writes a decoy start during the previous line, whose window would never open. It then writes the real start in the very cycle in which hsync falls. The line's pulse count, detect flag and interrupt timing are then compared against values computed from the real start. A wrong order of staging and loading shows up as a wrong count or a missing interrupt. The other lines check that a mid-line write leaves the running line alone.

// File: rtl/caption_runin_det.sv
module caption_runin_det #(
  parameter int WIN_W   = 8,
  parameter int CNT_W   = 3,
  parameter int DW      = 8,
  parameter int RUN_MIN = 4,
  parameter int RUN_MAX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slice_in,
  input  logic             hsync,
  input  logic             line_sel,
  input  logic             latch_done,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [CNT_W-1:0] main_count,
  output logic [CNT_W-1:0] sub_count,
  output logic             runin_ok,
  output logic             sub_latched,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [WIN_W-1:0] PMAX = '1;
  localparam logic [CNT_W-1:0] LO   = CNT_W'(RUN_MIN);
  localparam logic [CNT_W-1:0] HI   = CNT_W'(RUN_MAX);

  logic             hs_q;
  logic [2:0]       sync;
  logic [WIN_W-1:0] pend_start, pend_len, win_start, win_len, pos;
  logic             live, cur_sub, irq_line, irq_mode;

  wire              hs_fall   = hs_q & ~hsync;
  wire              rise      = sync[1] & ~sync[2];
  wire              wr_start  = wr_en && (wr_addr == 2'd0);
  wire              wr_len    = wr_en && (wr_addr == 2'd1);
  wire              wr_ctrl   = wr_en && (wr_addr == 2'd2);
  wire [WIN_W-1:0]  start_nxt = wr_start ? wr_data[WIN_W-1:0] : pend_start;
  wire [WIN_W-1:0]  len_nxt   = wr_len   ? wr_data[WIN_W-1:0] : pend_len;
  wire [WIN_W:0]    win_end   = {1'b0, win_start} + {1'b0, win_len};
  wire              in_win    = live && (pos >= win_start) && ({1'b0, pos} < win_end);
  wire              win_close = live && ({1'b0, pos} == win_end);
  wire [CNT_W-1:0]  cur_cnt   = cur_sub ? sub_count : main_count;
  wire              bump      = in_win && rise && (cur_cnt != CMAX);
  wire              line_hit  = (cur_sub == irq_line);
  wire              irq_cond  = line_hit && (irq_mode ? latch_done : win_close);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q        <= 1'b0;
      sync        <= '0;
      pend_start  <= '0;
      pend_len    <= '0;
      win_start   <= '0;
      win_len     <= '0;
      pos         <= '0;
      live        <= 1'b0;
      cur_sub     <= 1'b0;
      irq_line    <= 1'b0;
      irq_mode    <= 1'b0;
      main_count  <= '0;
      sub_count   <= '0;
      runin_ok    <= 1'b0;
      sub_latched <= 1'b0;
      irq         <= 1'b0;
    end else begin
      hs_q       <= hsync;
      sync       <= {sync[1:0], slice_in};
      pend_start <= start_nxt;
      pend_len   <= len_nxt;
      if (wr_ctrl) begin
        irq_line <= wr_data[0];
        irq_mode <= wr_data[1];
      end
      irq <= irq_cond && !hs_fall;
      if (hs_fall) begin
        win_start   <= start_nxt;
        win_len     <= len_nxt;
        pos         <= '0;
        live        <= 1'b1;
        cur_sub     <= line_sel;
        runin_ok    <= 1'b0;
        sub_latched <= 1'b0;
        if (line_sel) sub_count  <= '0;
        else          main_count <= '0;
      end else begin
        if (pos != PMAX) pos <= pos + 1'b1;
        if (win_close) begin
          live     <= 1'b0;
          runin_ok <= (cur_cnt >= LO) && (cur_cnt <= HI);
        end
        if (bump) begin
          if (cur_sub) sub_count  <= sub_count + 1'b1;
          else         main_count <= main_count + 1'b1;
        end
        if (latch_done && cur_sub) sub_latched <= 1'b1;
      end
    end
  end

  a_r5_window_held: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_fall |=> ($stable(win_start) && $stable(win_len)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (main_count == CMAX && !hs_fall) |=> (main_count == CMAX));

  a_r2_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fall && line_sel) |=> (main_count == $past(main_count)));

  a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall |=> !sub_latched);

  a_r4_detect_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(runin_ok) |-> (cur_cnt >= LO && cur_cnt <= HI));

  a_r8_close_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && !irq_mode && line_hit && !hs_fall) |=> irq);

endmodule

// File: tb/caption_runin_det_test.sv
module caption_runin_det_test;
  localparam int LINE = 40;
  localparam int NL   = 162;

  logic       clk = 0, rst_n = 0, slice_in = 0, hsync = 1, line_sel = 0;
  logic       latch_done = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] main_count, sub_count;
  logic       runin_ok, sub_latched, irq;
  int n_cmp = 0, n_bad = 0;
  int exp_cnt [2];

  always #5 clk = ~clk;

  caption_runin_det uut (
    .clk(clk), .rst_n(rst_n), .slice_in(slice_in), .hsync(hsync),
    .line_sel(line_sel), .latch_done(latch_done), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .main_count(main_count),
    .sub_count(sub_count), .runin_ok(runin_ok), .sub_latched(sub_latched),
    .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int st_of(input int i);  return (i / 54) % 3 == 0 ? 2 : ((i / 54) % 3 == 1 ? 5 : 9); endfunction
  function automatic int ln_of(input int i);  return (i / 18) % 3 == 0 ? 0 : ((i / 18) % 3 == 1 ? 6 : 20); endfunction
  function automatic int np_of(input int i);  return (i / 2) % 9; endfunction
  function automatic int off_of(input int i); return (i % 2) * 3; endfunction
  function automatic int sel_of(input int i); return (i % 2) ^ ((i / 5) % 2); endfunction
  function automatic int lat_of(input int i); return (i / 3) % 2; endfunction
  function automatic int md_of(input int i);  return (i / 7) % 2; endfunction
  function automatic int il_of(input int i);  return (i / 4) % 2; endfunction
  function automatic int col_of(input int i); return (i == 0) ? 0 : (i / 11) % 2; endfunction

  function automatic bit pulse_at(input int k, input int off, input int np);
    return (k >= off) && ((k - off) % 2 == 0) && ((k - off) / 2 < np);
  endfunction

  task automatic run_line(input int i);
    int st, ln, np, off, sel, lat, md, il, n, expc, irq_k, irq_n, exp_k, exp_n;
    st = st_of(i); ln = ln_of(i); np = np_of(i); off = off_of(i);
    sel = sel_of(i); lat = lat_of(i); md = md_of(i); il = il_of(i);
    n = 0;
    for (int k = 0; k < LINE; k++)
      if (pulse_at(k, off, np) && st <= k + 2 && k + 2 < st + ln) n++;
    expc = (n > 7) ? 7 : n;
    if (md == 0) begin exp_n = (sel == il) ? 1 : 0; exp_k = st + ln + 1; end
    else begin exp_n = (lat == 1 && sel == il) ? 1 : 0; exp_k = 11; end
    irq_k = -1; irq_n = 0;
    @(negedge clk);
    hsync = 0; line_sel = sel[0]; slice_in = 0;
    if (col_of(i) == 1) begin wr_en = 1; wr_addr = 2'd0; wr_data = 8'(st); end
    for (int k = 0; k < LINE; k++) begin
      @(negedge clk);
      if (irq) begin irq_n++; if (irq_k < 0) irq_k = k; end
      if (k == 0) begin
        chk("R6 sub_latched cleared at sync fall", int'(sub_latched), 0);
        chk("R4 runin_ok cleared at sync fall", int'(runin_ok), 0);
      end
      if (k == LINE - 1) begin
        exp_cnt[sel] = expc;
        chk("R1 R2 R3 R5 main_count", int'(main_count), exp_cnt[0]);
        chk("R1 R2 R3 R5 sub_count", int'(sub_count), exp_cnt[1]);
        chk("R4 runin_ok", int'(runin_ok), (expc >= 4 && expc <= 6) ? 1 : 0);
        chk("R6 sub_latched", int'(sub_latched), (sel == 1 && lat == 1) ? 1 : 0);
        chk("R7 R8 R9 irq pulse count", irq_n, exp_n);
        if (exp_n == 1) chk("R8 R9 irq cycle", irq_k, exp_k);
      end
      wr_en = 0; latch_done = 0;
      if (k >= 3) hsync = 1;
      slice_in = pulse_at(k, off, np);
      if (k == 10 && lat == 1) latch_done = 1;
      if (k == 30) begin
        wr_en = 1; wr_addr = 2'd0;
        wr_data = (col_of(i + 1) == 1) ? 8'd50 : 8'(st_of(i + 1));
      end
      if (k == 31) begin wr_en = 1; wr_addr = 2'd1; wr_data = 8'(ln_of(i + 1)); end
      if (k == 32) begin
        wr_en = 1; wr_addr = 2'd2;
        wr_data = 8'((md_of(i + 1) << 1) | il_of(i + 1));
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    exp_cnt[0] = 0; exp_cnt[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 main_count reset", int'(main_count), 0);
    chk("R10 sub_count reset", int'(sub_count), 0);
    chk("R10 runin_ok reset", int'(runin_ok), 0);
    chk("R10 sub_latched reset", int'(sub_latched), 0);
    chk("R10 irq reset", int'(irq), 0);
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'(st_of(0));
    @(negedge clk);
    wr_addr = 2'd1; wr_data = 8'(ln_of(0));
    @(negedge clk);
    wr_addr = 2'd2; wr_data = 8'((md_of(0) << 1) | il_of(0));
    @(negedge clk);
    wr_en = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NL; i++) run_line(i);
    summary();
    $finish;
  end
endmodule